// File: doc/BRIEF.md
# Two-Layer Perceptron Row Evaluator

This block runs the inference pass of a small two-layer perceptron in fixed-point arithmetic. It uses a grid of multiply-accumulate elements with `N_HID` rows of `COLS` elements. Each row produces the weighted sum of one neuron. The row passes that sum through a hyperbolic-tangent lookup table to form the neuron's signed 8-bit activation. The first pass over the grid computes the hidden layer. The hidden activations are then fed back through the same rows, and rows `0..N_OUT-1` compute the output layer.

A whole input vector arrives in one valid/ready beat. The result leaves as one beat that holds all output activations, and it stays stable until the consumer accepts it. Each element has its own weight memory. An address counter inside the element steps through that memory in step with the states applied to it. A write port fills the weight memories while the evaluator is idle. Only one vector is in flight at a time.

Top module: `mlp_row_eval`

## Requirements
- R1: After reset `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: Inputs and weights are signed two's complement values. Hidden activation j is `T(S(sum_i x_i * W[j][i mod COLS][i div COLS]))`. Here `W[r][c][a]` is the word written at row r, column c and address a.
- R3: Output activation k is `T(S(sum_j h_j * W[k][j mod COLS][N_IN/COLS + j div COLS]))`, where h_j is hidden activation j from R2.
- R4: Table T maps an index n in -128..127 as follows. With a = |n|, the entry is `sign(n) * min(127, floor(127*a*(27648+a*a) / (32*(27648+9*a*a))))`.
- R5: Index function S shifts the sum right arithmetically by `ACT_SHIFT` bits (this rounds toward minus infinity). It then clamps the result to -128..127.
- R6: Input i occupies bits `[8i+7:8i]` of `in_data_i`, and output k occupies bits `[8k+7:8k]` of `out_data_o`.
- R7: `out_valid_o` rises exactly `N_IN/COLS + N_HID/COLS + 2` clock edges after the edge that accepts a vector.
- R8: `in_ready_o` stays 0 from the accepting edge until the edge that takes the output. Any input beat offered in that time is ignored. `in_ready_o` returns to 1 on the edge that takes the output.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` stays 1 and `out_data_o` holds its value.
- R10: A weight write made while `in_ready_o` is 0 changes no weight.
- R11: Sums built from the most negative state and weight values over every term are computed without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input vector valid |
| in_ready_o | output | 1 | Evaluator idle, ready to accept a vector |
| in_data_i | input | 8*N_IN | Packed signed input states |
| out_valid_o | output | 1 | Output activations valid |
| out_ready_i | input | 1 | Consumer takes the output |
| out_data_o | output | 8*N_OUT | Packed signed output activations |
| wr_en_i | input | 1 | Weight write strobe |
| wr_row_i | input | max(1,clog2(N_HID)) | Row of the target element |
| wr_col_i | input | max(1,clog2(COLS)) | Column of the target element |
| wr_addr_i | input | max(1,clog2((N_IN+N_HID)/COLS)) | Word address in the element's weight memory |
| wr_data_i | input | 16 | Signed weight word |

## Verification
With the default parameters, a result is due eight edges after the accepting edge. That is four hidden-layer multiply-accumulate steps, one activation edge, two output-layer steps, and one final activation edge. The bench counts falling edges from the accepting edge until `out_valid_o` is seen, checks that count against this figure, and checks that `in_ready_o` stays low on every falling edge before it. The outputs are compared on the falling edge where valid first appears, and again after a hold period with ready held low. The bench then checks readiness on the falling edge right after the output is taken, which shows that this happens in a single cycle.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

  localparam int STATE_W = 8;
  localparam int WGT_W   = 16;
  localparam int PROD_W  = STATE_W + WGT_W;

  typedef enum logic [2:0] {
    EV_IDLE, EV_L1, EV_ACT1, EV_L2, EV_ACT2, EV_DONE
  } ev_state_e;

  // Rational tanh approximation, index scaled by 1/32, output by 127.
  function automatic logic signed [STATE_W-1:0] tanh_entry(input int idx);
    longint a, num, den, y;
    a   = (idx < 0) ? -longint'(idx) : longint'(idx);
    num = 127 * a * (27648 + a * a);
    den = 32 * (27648 + 9 * a * a);
    y   = num / den;
    if (y > 127) y = 127;
    return (idx < 0) ? STATE_W'(-y) : STATE_W'(y);
  endfunction

endpackage

// File: rtl/mlp_pe.sv
module mlp_pe import mlp_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int AW    = 3,
  parameter int ACC_W = 28
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    clr_i,
  input  logic                    mac_en_i,
  input  logic signed [STATE_W-1:0] state_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic signed [WGT_W-1:0] wdata_i,
  output logic signed [ACC_W-1:0] acc_o
);

  logic signed [WGT_W-1:0]  mem [DEPTH];
  logic [AW-1:0]            addr_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [PROD_W-1:0] prod;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign prod = PROD_W'(state_i) * PROD_W'(mem[addr_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      acc_q  <= '0;
    end else begin
      if (start_i)       addr_q <= '0;
      else if (mac_en_i) addr_q <= addr_q + 1'b1;
      if (clr_i)         acc_q  <= '0;
      else if (mac_en_i) acc_q  <= acc_q + ACC_W'(prod);
    end
  end

  assign acc_o = acc_q;

  assert_addr_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_en_i |-> (int'(addr_q) < DEPTH));

endmodule

// File: rtl/mlp_act.sv
module mlp_act import mlp_pkg::*; #(
  parameter int ACC_W = 28,
  parameter int SHIFT = 8
) (
  input  logic signed [ACC_W-1:0]   sum_i,
  output logic signed [STATE_W-1:0] act_o
);

  localparam logic signed [ACC_W-1:0] IDX_HI = 127;
  localparam logic signed [ACC_W-1:0] IDX_LO = -128;

  logic signed [STATE_W-1:0] rom [256];
  logic signed [ACC_W-1:0]   sh;
  logic [STATE_W-1:0]        idx;

  for (genvar g = 0; g < 256; g++) begin : g_rom
    assign rom[g] = tanh_entry(g - 128);
  end

  always_comb begin
    sh = sum_i >>> SHIFT;
    if (sh > IDX_HI)      idx = 8'h7f;
    else if (sh < IDX_LO) idx = 8'h80;
    else                  idx = sh[STATE_W-1:0];
  end

  // offset-binary address: -128 -> 0, 127 -> 255
  assign act_o = rom[idx ^ 8'h80];

endmodule

// File: rtl/mlp_row.sv
module mlp_row import mlp_pkg::*; #(
  parameter int COLS      = 4,
  parameter int DEPTH     = 6,
  parameter int AW        = 3,
  parameter int ACC_W     = 28,
  parameter int ACT_SHIFT = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      clr_i,
  input  logic                      mac_en_i,
  input  logic [COLS*STATE_W-1:0]   states_i,
  input  logic [COLS-1:0]           we_i,
  input  logic [AW-1:0]             waddr_i,
  input  logic signed [WGT_W-1:0]   wdata_i,
  output logic signed [STATE_W-1:0] act_o
);

  logic signed [ACC_W-1:0] acc [COLS];
  logic signed [ACC_W-1:0] sum;

  for (genvar c = 0; c < COLS; c++) begin : g_pe
    mlp_pe #(.DEPTH(DEPTH), .AW(AW), .ACC_W(ACC_W)) u_pe (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .clr_i    (clr_i),
      .mac_en_i (mac_en_i),
      .state_i  (states_i[c*STATE_W +: STATE_W]),
      .we_i     (we_i[c]),
      .waddr_i  (waddr_i),
      .wdata_i  (wdata_i),
      .acc_o    (acc[c])
    );
  end

  always_comb begin
    sum = '0;
    for (int c = 0; c < COLS; c++) sum = sum + acc[c];
  end

  mlp_act #(.ACC_W(ACC_W), .SHIFT(ACT_SHIFT)) u_act (
    .sum_i (sum),
    .act_o (act_o)
  );

endmodule

// File: rtl/mlp_row_eval.sv
module mlp_row_eval import mlp_pkg::*; #(
  parameter int N_IN      = 16,
  parameter int N_HID     = 8,
  parameter int N_OUT     = 4,
  parameter int COLS      = 4,
  parameter int ACT_SHIFT = 8,
  localparam int D1    = N_IN / COLS,
  localparam int D2    = N_HID / COLS,
  localparam int DEPTH = D1 + D2,
  localparam int RW    = (N_HID > 1) ? $clog2(N_HID) : 1,
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [N_IN*STATE_W-1:0]  in_data_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [N_OUT*STATE_W-1:0] out_data_o,
  input  logic                     wr_en_i,
  input  logic [RW-1:0]            wr_row_i,
  input  logic [CW-1:0]            wr_col_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [WGT_W-1:0]         wr_data_i
);

  localparam int MAX_N = (N_IN > N_HID) ? N_IN : N_HID;
  localparam int ACC_W = PROD_W + $clog2(MAX_N);
  localparam int LAT   = D1 + D2 + 2;
  localparam int SW    = $clog2(MAX_N + 1);
  localparam int LW    = $clog2(LAT + 2);

  ev_state_e                 state_q;
  logic [SW-1:0]             step_q;
  logic [N_IN*STATE_W-1:0]   x_q;
  logic [N_HID*STATE_W-1:0]  h_q;
  logic [N_OUT*STATE_W-1:0]  y_q;
  logic [COLS*STATE_W-1:0]   col_st;
  logic signed [STATE_W-1:0] act [N_HID];
  logic accept, mac_en, clr, last_step, wr_ok;

  assign in_ready_o  = (state_q == EV_IDLE);
  assign out_valid_o = (state_q == EV_DONE);
  assign out_data_o  = y_q;
  assign accept      = in_valid_i && in_ready_o;
  assign mac_en      = (state_q == EV_L1) || (state_q == EV_L2);
  assign clr         = accept || (state_q == EV_ACT1);
  assign last_step   = (state_q == EV_L1) ? (step_q == SW'(D1 - 1)) : (step_q == SW'(D2 - 1));
  assign wr_ok       = wr_en_i && in_ready_o && (int'(wr_addr_i) < DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EV_IDLE;
      step_q  <= '0;
      x_q     <= '0;
      h_q     <= '0;
      y_q     <= '0;
    end else begin
      unique case (state_q)
        EV_IDLE: if (accept) begin
          x_q     <= in_data_i;
          step_q  <= '0;
          state_q <= EV_L1;
        end
        EV_L1: begin
          step_q <= last_step ? '0 : step_q + 1'b1;
          if (last_step) state_q <= EV_ACT1;
        end
        EV_ACT1: begin
          for (int j = 0; j < N_HID; j++) h_q[j*STATE_W +: STATE_W] <= act[j];
          state_q <= EV_L2;
        end
        EV_L2: begin
          step_q <= last_step ? '0 : step_q + 1'b1;
          if (last_step) state_q <= EV_ACT2;
        end
        EV_ACT2: begin
          for (int k = 0; k < N_OUT; k++) y_q[k*STATE_W +: STATE_W] <= act[k];
          state_q <= EV_DONE;
        end
        EV_DONE: if (out_ready_i) state_q <= EV_IDLE;
        default: state_q <= EV_IDLE;
      endcase
    end
  end

  // column c takes state index step*COLS + c of the current layer
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_st[c*STATE_W +: STATE_W] = (state_q == EV_L2)
      ? h_q[STATE_W*(int'(step_q)*COLS + c) +: STATE_W]
      : x_q[STATE_W*(int'(step_q)*COLS + c) +: STATE_W];
  end

  for (genvar r = 0; r < N_HID; r++) begin : g_row
    logic [COLS-1:0] we;
    for (genvar c = 0; c < COLS; c++) begin : g_we
      assign we[c] = wr_ok && (wr_row_i == RW'(r)) && (wr_col_i == CW'(c));
    end
    mlp_row #(.COLS(COLS), .DEPTH(DEPTH), .AW(AW), .ACC_W(ACC_W),
              .ACT_SHIFT(ACT_SHIFT)) u_row (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (accept),
      .clr_i    (clr),
      .mac_en_i (mac_en),
      .states_i (col_st),
      .we_i     (we),
      .waddr_i  (wr_addr_i),
      .wdata_i  (signed'(wr_data_i)),
      .act_o    (act[r])
    );
  end

  // latency window counter for the checker
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         lat_q <= '0;
    else if (accept)                                     lat_q <= '0;
    else if (state_q != EV_IDLE && state_q != EV_DONE)   lat_q <= lat_q + 1'b1;
  end

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (lat_q == LW'(LAT)));

  assert_input_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> $stable(x_q));

  assert_ready_after_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> in_ready_o);

  assert_output_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

endmodule

// File: tb/mlp_row_eval_test.sv
module mlp_row_eval_test;

  localparam int N_IN  = 16;
  localparam int N_HID = 8;
  localparam int N_OUT = 4;
  localparam int COLS  = 4;
  localparam int SHIFT = 8;
  localparam int D1    = N_IN / COLS;
  localparam int D2    = N_HID / COLS;
  localparam int DEPTH = D1 + D2;
  localparam int LAT   = D1 + D2 + 2;
  localparam int IN_W  = N_IN * 8;
  localparam int OUT_W = N_OUT * 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [IN_W-1:0]  in_data = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [OUT_W-1:0] out_data;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_row = '0;
  logic [1:0]       wr_col = '0;
  logic [2:0]       wr_addr = '0;
  logic [15:0]      wr_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int wm [N_HID][COLS][DEPTH];

  always #2 clk = ~clk;

  mlp_row_eval #(.N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT), .COLS(COLS),
                 .ACT_SHIFT(SHIFT)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .wr_en_i(wr_en), .wr_row_i(wr_row), .wr_col_i(wr_col),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lut_m(input int n);
    longint a, y;
    a = (n < 0) ? -n : n;
    y = (127 * a * (27648 + a * a)) / (32 * (27648 + 9 * a * a));
    if (y > 127) y = 127;
    return (n < 0) ? -int'(y) : int'(y);
  endfunction

  function automatic int sat8(input longint v);
    if (v > 127)  return 127;
    if (v < -128) return -128;
    return int'(v);
  endfunction

  function automatic logic [OUT_W-1:0] model(input logic [IN_W-1:0] x);
    int h [N_HID];
    longint s;
    logic [OUT_W-1:0] o;
    for (int j = 0; j < N_HID; j++) begin
      s = 0;
      for (int i = 0; i < N_IN; i++)
        s += longint'($signed(x[8*i +: 8])) * wm[j][i % COLS][i / COLS];
      h[j] = lut_m(sat8(s >>> SHIFT));
    end
    for (int k = 0; k < N_OUT; k++) begin
      s = 0;
      for (int j = 0; j < N_HID; j++)
        s += longint'(h[j]) * wm[k][j % COLS][D1 + j / COLS];
      o[8*k +: 8] = 8'(lut_m(sat8(s >>> SHIFT)));
    end
    return o;
  endfunction

  task automatic put_w(input int r, input int c, input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_row = 3'(r); wr_col = 2'(c); wr_addr = 3'(a); wr_data = 16'(d);
    wm[r][c][a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int seed, input int fixed, input bit use_fixed);
    for (int r = 0; r < N_HID; r++)
      for (int c = 0; c < COLS; c++)
        for (int a = 0; a < DEPTH; a++)
          put_w(r, c, a, use_fixed ? fixed : (((r*37 + c*11 + a*5 + seed*13) % 61) - 30) * 2);
  endtask

  function automatic logic [IN_W-1:0] vec(input int seed);
    logic [IN_W-1:0] x;
    for (int i = 0; i < N_IN; i++) x[8*i +: 8] = 8'(((i*29 + seed*7) % 256) - 128);
    return x;
  endfunction

  // one evaluation; checks latency, busy readiness, results, hold and release
  task automatic run_vec(input logic [IN_W-1:0] x, input int hold, input bit disturb,
                         input string req);
    logic [OUT_W-1:0] exp, snap;
    int n;
    bit rdy_bad, hold_bad;
    exp = model(x);
    @(negedge clk);
    in_data = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; n = 0; rdy_bad = 0;
    while (!out_valid && n < LAT + 20) begin
      if (in_ready) rdy_bad = 1;
      if (disturb && n == 0) begin
        in_valid = 1'b1; in_data = ~x;
        wr_en = 1'b1; wr_row = '0; wr_col = '0; wr_addr = '0; wr_data = 16'sd12345;
      end else begin
        in_valid = 1'b0; wr_en = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0; wr_en = 1'b0;
    check(n == LAT, "R7", "latency", n, LAT);
    check(!rdy_bad, "R8", "in_ready low while busy", rdy_bad, 0);
    for (int k = 0; k < N_OUT; k++)
      check(out_data[8*k +: 8] == exp[8*k +: 8], req, $sformatf("R6 out[%0d]", k),
            $signed(out_data[8*k +: 8]), $signed(exp[8*k +: 8]));
    snap = out_data; hold_bad = 0;
    for (int t = 0; t < hold; t++) begin
      @(negedge clk);
      if (!out_valid || out_data != snap) hold_bad = 1;
    end
    if (hold > 0) check(!hold_bad, "R9", "output held", hold_bad, 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready && !out_valid, "R8", "ready after take", {in_ready, out_valid}, 2);
  endtask

  task automatic t_reset;
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_basic;
    load(1, 0, 0);
    run_vec(vec(1), 0, 0, "R2 R3");
    run_vec(vec(2), 0, 0, "R2 R3");
    load(5, 0, 0);
    run_vec(vec(3), 0, 0, "R2 R3");
  endtask

  task automatic t_hold;
    run_vec(vec(4), 6, 0, "R9");
  endtask

  task automatic t_busy;
    run_vec(vec(6), 0, 1, "R8 R10");
    run_vec(vec(6), 0, 0, "R10 weight unchanged");
  endtask

  // h0 forced to 127, output k = T(floor(127*w_k/256)) for chosen w_k
  task automatic t_lut;
    logic [IN_W-1:0] x;
    int wl [12] = '{-32768, -200, -80, -3, 0, 2, 3, 10, 64, 130, 200, 32767};
    load(0, 0, 1);
    put_w(0, 0, 0, 127 * 256);
    x = '0; x[7:0] = 8'd1;
    for (int g = 0; g < 3; g++) begin
      for (int k = 0; k < N_OUT; k++) put_w(k, 0, D1, wl[g*4 + k]);
      run_vec(x, 0, 0, "R4 R5");
    end
  endtask

  task automatic t_extreme;
    logic [IN_W-1:0] x;
    for (int i = 0; i < N_IN; i++) x[8*i +: 8] = 8'h80;
    load(0, -32768, 1);
    run_vec(x, 0, 0, "R5 R11");
    for (int r = 0; r < N_OUT; r++)
      for (int c = 0; c < COLS; c++)
        for (int a = D1; a < DEPTH; a++) put_w(r, c, a, 32767);
    run_vec(x, 0, 0, "R5 R11");
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hold();
    t_busy();
    t_lut();
    t_extreme();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule